// File: doc/BRIEF.md
# Pin-Edge Count Capture and Clear Unit

This unit watches an asynchronous external pin and reacts to a chosen transition on it by acting on a 24-bit timer count. The count itself lives in a separate counter. In capture mode, a matching edge copies the live count into a holding register and raises a pending flag. In clear mode, the same edge sends a one-cycle request to the counter to return to zero. Software clears the flag with a write-one strobe. An interrupt line follows the flag when the interrupt enable is set.

The pin passes through a two-stage synchroniser. An optional debounce filter can sit before the edge detector. The filter accepts a new pin level only after it has stayed the same for three consecutive clocks. While the flag is pending, later capture events are dropped, so the first captured value is kept until software takes it.

Top module: `edge_capture_unit`

## Requirements
- R1: With debounce off, a matching pin transition driven between two clock edges takes effect on the third rising clock edge after it. The flag or the clear request is visible after that edge and not before.
- R2: The 2-bit edge select picks the transition: 00 selects falling, 01 selects rising, 10 selects both. A transition of the other direction has no effect.
- R3: Edge select 11 matches no transition, in either function.
- R4: With function select 0, a matching edge loads countIn, as sampled on the clock edge that sets the flag, into capValue and sets capFlag.
- R5: With function select 1, a matching edge makes cntClearReq high for exactly one cycle. capFlag and capValue are left unchanged.
- R6: While capFlag is 1, further capture events are dropped and capValue keeps its value.
- R7: A one-cycle flagClear strobe clears capFlag on the next clock edge. If a capture event arrives on the same edge, the set takes priority.
- R8: irqOut is high exactly when irqEnable and capFlag are both 1.
- R9: While capEnable is 0, pin transitions cause no capture and no clear request.
- R10: With debounce on, the synchronised level must stay the same for 3 consecutive clocks before it is accepted. A 2-clock pulse is ignored. A held change sets the flag after the sixth rising edge, not after the fifth.
- R11: After reset, capFlag, capValue, cntClearReq and irqOut are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 1 | External asynchronous pin |
| countIn | input | 24 | Live timer count |
| capEnable | input | 1 | Enables reaction to the pin |
| edgeSel | input | 2 | Edge code: 00 fall, 01 rise, 10 both, 11 none |
| funcSel | input | 1 | 0 capture, 1 clear the counter |
| irqEnable | input | 1 | Interrupt enable |
| debounceEn | input | 1 | Selects the debounced pin level |
| flagClear | input | 1 | Write-one-to-clear strobe for the flag |
| capValue | output | 24 | Captured count |
| capFlag | output | 1 | Capture pending flag |
| cntClearReq | output | 1 | One-cycle request to clear the counter |
| irqOut | output | 1 | Interrupt line |

## Verification
Some properties are checked by assertions on every cycle:
- a pending flag freezes the captured value, and a clear strobe drops the flag;
- a flag rise or a clear request only follows a cycle with the unit enabled and the matching function selected;
- the reserved edge code never produces an event.

Other behaviour can only be shown by the bench's scenarios:
- the exact edge-to-output latency, with and without debounce;
- the direction decoding of each edge code;
- the value that was captured;
- rejection of a short glitch.

// File: rtl/edge_cap_pkg.sv
package edge_cap_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic loadCap;
    logic setFlag;
    logic clrFlag;
    logic pulseClr;
  } cap_strobe_t;
endpackage

// File: rtl/edge_cap_ctrl.sv
module edge_cap_ctrl
  import edge_cap_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int DEBOUNCE_LEN = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinIn,
  input  logic        capEnable,
  input  logic [1:0]  edgeSel,
  input  logic        funcSel,
  input  logic        debounceEn,
  input  logic        flagClear,
  input  logic        capFlag,
  output cap_strobe_t strobes
);
  localparam int HIST_W = DEBOUNCE_LEN - 1;

  // synchroniser chain
  logic [SYNC_STAGES-1:0] syncChain;
  logic syncLvl;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
  end
  assign syncLvl = syncChain[SYNC_STAGES-1];

  // debounce: accept a level once the whole window agrees
  logic [HIST_W-1:0]       hist;
  logic [DEBOUNCE_LEN-1:0] window;
  logic stableLvl, dbLvl;
  assign window    = {hist, syncLvl};
  assign stableLvl = (&window) | ~(|window);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist  <= '0;
      dbLvl <= 1'b0;
    end else begin
      hist <= window[HIST_W-1:0];
      if (stableLvl) dbLvl <= syncLvl;
    end
  end

  // edge detection on the selected level
  logic curLvl, prevLvl, riseHit, fallHit, edgeHit, eventHit;
  edge_mode_e mode;
  assign curLvl = debounceEn ? dbLvl : syncLvl;
  assign mode   = edge_mode_e'(edgeSel);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= curLvl;
  end
  assign riseHit = curLvl & ~prevLvl;
  assign fallHit = ~curLvl & prevLvl;

  always_comb begin
    case (mode)
      EDGE_FALL: edgeHit = fallHit;
      EDGE_RISE: edgeHit = riseHit;
      EDGE_BOTH: edgeHit = riseHit | fallHit;
      default:   edgeHit = 1'b0;
    endcase
  end
  assign eventHit = edgeHit & capEnable;

  always_comb begin
    strobes.loadCap  = eventHit & ~funcSel & ~capFlag;
    strobes.setFlag  = eventHit & ~funcSel & ~capFlag;
    strobes.clrFlag  = flagClear;
    strobes.pulseClr = eventHit & funcSel;
  end
endmodule

// File: rtl/edge_cap_dp.sv
module edge_cap_dp
  import edge_cap_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  cap_strobe_t      strobes,
  input  logic [CNT_W-1:0] countIn,
  output logic [CNT_W-1:0] capValue,
  output logic             capFlag,
  output logic             cntClearReq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValue    <= '0;
      capFlag     <= 1'b0;
      cntClearReq <= 1'b0;
    end else begin
      if (strobes.loadCap) capValue <= countIn;
      if (strobes.setFlag)      capFlag <= 1'b1;
      else if (strobes.clrFlag) capFlag <= 1'b0;
      cntClearReq <= strobes.pulseClr;
    end
  end

  // R6: pending flag freezes the held count
  p_hold_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    capFlag |=> $stable(capValue));

  // R7: a clear strobe on a pending flag drops it
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && strobes.clrFlag) |=> !capFlag);
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import edge_cap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinIn,
  input  logic [23:0] countIn,
  input  logic        capEnable,
  input  logic [1:0]  edgeSel,
  input  logic        funcSel,
  input  logic        irqEnable,
  input  logic        debounceEn,
  input  logic        flagClear,
  output logic [23:0] capValue,
  output logic        capFlag,
  output logic        cntClearReq,
  output logic        irqOut
);
  cap_strobe_t strobes;

  edge_cap_ctrl #(.SYNC_STAGES(2), .DEBOUNCE_LEN(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .capEnable(capEnable),
    .edgeSel(edgeSel), .funcSel(funcSel), .debounceEn(debounceEn),
    .flagClear(flagClear), .capFlag(capFlag), .strobes(strobes)
  );

  edge_cap_dp #(.CNT_W(24)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .countIn(countIn),
    .capValue(capValue), .capFlag(capFlag), .cntClearReq(cntClearReq)
  );

  assign irqOut = irqEnable & capFlag;

  // R5: a clear request only follows an enabled cycle in clear mode
  p_clear_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    cntClearReq |-> $past(funcSel && capEnable));

  // R4: the flag only rises after an enabled cycle in capture mode
  p_flag_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capFlag) |-> $past(!funcSel && capEnable));

  // R3: reserved edge code yields no event
  p_reserved_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(edgeSel) == 2'b11) |-> (!$rose(capFlag) && !cntClearReq));

  // R9: disabled unit yields no event
  p_disabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(capEnable) |-> (!$rose(capFlag) && !cntClearReq));
endmodule

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinIn = 1'b0;
  logic [23:0] countIn = '0;
  logic        capEnable = 1'b0;
  logic [1:0]  edgeSel = 2'b00;
  logic        funcSel = 1'b0;
  logic        irqEnable = 1'b0;
  logic        debounceEn = 1'b0;
  logic        flagClear = 1'b0;
  logic [23:0] capValue;
  logic        capFlag, cntClearReq, irqOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [23:0] lastCap = '0;

  always #5 clk = ~clk;

  edge_capture_unit u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .countIn(countIn),
    .capEnable(capEnable), .edgeSel(edgeSel), .funcSel(funcSel),
    .irqEnable(irqEnable), .debounceEn(debounceEn), .flagClear(flagClear),
    .capValue(capValue), .capFlag(capFlag), .cntClearReq(cntClearReq),
    .irqOut(irqOut)
  );

  // fields: [7:6] edge, [5] func, [4] irqEn, [3] from, [2] to, [1] expFlag, [0] expClr
  localparam logic [7:0] VEC [12] = '{
    8'b00_0_1_1_0_1_0, 8'b00_0_1_0_1_0_0, 8'b01_0_1_0_1_1_0, 8'b01_0_0_1_0_0_0,
    8'b10_0_1_0_1_1_0, 8'b10_0_0_1_0_1_0, 8'b11_0_1_0_1_0_0, 8'b11_0_1_1_0_0_0,
    8'b01_1_1_0_1_0_1, 8'b00_1_0_1_0_0_1, 8'b10_1_1_1_0_0_1, 8'b11_1_1_0_1_0_0
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearFlag();
    flagClear = 1'b1;
    step(1);
    flagClear = 1'b0;
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    // R11 reset state
    check("R11", "capFlag", capFlag, 0);
    check("R11", "capValue", capValue, 0);
    check("R11", "cntClearReq", cntClearReq, 0);
    check("R11", "irqOut", irqOut, 0);
    rstN = 1'b1;
    step(2);

    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      string req;
      v = VEC[i];
      req = (v[7:6] == 2'b11) ? "R3" : (v[5] ? "R5" : "R2");
      capEnable = 1'b0;
      debounceEn = 1'b0;
      pinIn = v[3];
      step(6);
      clearFlag();
      edgeSel = v[7:6];
      funcSel = v[5];
      irqEnable = v[4];
      countIn = 24'h100000 + 24'(i * 4099);
      capEnable = 1'b1;
      step(1);
      pinIn = v[2];
      step(3);
      check(req, "capFlag", capFlag, v[1]);
      check(req, "cntClearReq", cntClearReq, v[0]);
      if (v[1]) lastCap = countIn;
      check("R4", "capValue", capValue, lastCap);
      check("R8", "irqOut", irqOut, v[1] & v[4]);
      step(1);
      check("R5", "cntClearReq single cycle", cntClearReq, 0);
    end

    // R1 latency and R6 drop while pending (both-edge capture)
    capEnable = 1'b0;
    pinIn = 1'b0;
    step(6);
    clearFlag();
    edgeSel = 2'b10;
    funcSel = 1'b0;
    irqEnable = 1'b1;
    capEnable = 1'b1;
    countIn = 24'hABCDEF;
    step(1);
    pinIn = 1'b1;
    step(2);
    check("R1", "capFlag before third edge", capFlag, 0);
    step(1);
    check("R1", "capFlag after third edge", capFlag, 1);
    check("R4", "capValue", capValue, 24'hABCDEF);
    countIn = 24'h123456;
    pinIn = 1'b0;
    step(5);
    check("R6", "capFlag still pending", capFlag, 1);
    check("R6", "capValue kept", capValue, 24'hABCDEF);
    clearFlag();
    check("R7", "capFlag cleared", capFlag, 0);
    check("R8", "irqOut low after clear", irqOut, 0);

    // R9 disabled: toggles ignored
    capEnable = 1'b0;
    pinIn = 1'b1;
    step(4);
    pinIn = 1'b0;
    step(5);
    check("R9", "capFlag disabled", capFlag, 0);
    check("R9", "capValue disabled", capValue, 24'hABCDEF);

    // R10 debounce: 2-clock glitch rejected, held level accepted late
    debounceEn = 1'b1;
    edgeSel = 2'b01;
    pinIn = 1'b0;
    step(8);
    capEnable = 1'b1;
    countIn = 24'h0F0F0F;
    step(1);
    pinIn = 1'b1;
    step(2);
    pinIn = 1'b0;
    step(10);
    check("R10", "glitch rejected", capFlag, 0);
    pinIn = 1'b1;
    step(5);
    check("R10", "capFlag after fifth edge", capFlag, 0);
    step(1);
    check("R10", "capFlag after sixth edge", capFlag, 1);
    check("R10", "capValue debounced", capValue, 24'h0F0F0F);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule